// File: doc/BRIEF.md
# Register File Address Translator

This block sits between the operand decoder of an 8-bit microcontroller and its 256-entry register file. It turns an instruction's register operand into an absolute 8-bit register file address. The operand can be a 4-bit working register number or an 8-bit absolute register address. The block also decides whether the resulting access lands in the paged top group. If it does, the block supplies the page number that selects which peripheral bank the access reaches.

The block holds three pointer registers: a low working pointer, a high working pointer and a page pointer. Set commands update them. Working register numbers resolve in one of two modes, chosen by a mode bit that the working-pointer commands write:

- **Single mode:** one 16-register window, based on the low pointer.
- **Twin mode:** two independent 8-register windows.

Translation is combinational. A pointer write made in a cycle affects translations from the following clock edge onward. The block does not hold the register storage array and does not decode instructions.

Top module: `rf_addr_xlat`

## Requirements
- R1: An absolute operand (`opnd_work_i`=0) whose high nibble is neither 0xD nor 0xF appears unchanged on `addr_o`. For it, `paged_o`=0 and `page_o`=0.
- R2: When the resolved address lies in 240–255, `paged_o`=1 and `page_o` equals the page pointer's page number. For every other address, `paged_o`=0 and `page_o`=0.
- R3: Command code 1 (set single pointer) does three things. It loads `cmd_arg_i[7:3]` into the low pointer group. It clears the mode bit, so both images show bit 2 = 0. It leaves the high pointer group unchanged.
- R4: Command code 2 loads `cmd_arg_i[7:3]` into the low pointer group. Command code 3 loads it into the high pointer group. Both commands set the mode bit to twin (bit 2 = 1 in both images).
- R5: Bits 1:0 of `rp_lo_o`, `rp_hi_o` and `pg_o` always read 0, whatever was written to them.
- R6: In single mode, working number n resolves to `{rp_lo[7:4], n}`. An odd low group therefore behaves like the even group below it.
- R7: In twin mode, n in 0–7 resolves to low group × 8 + n, and n in 8–15 resolves to high group × 8 + (n − 8).
- R8: An absolute operand with high nibble 0xD is treated as a working register reference. Its low nibble is the working number.
- R9: Command code 4 loads `cmd_arg_i[7:2]` into the page pointer. The page pointer keeps its value until the next code 4. Code 0 and codes 5–7 change no pointer.
- R10: A translation in the same cycle as a pointer command uses the pointer values from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cmd_i | input | 3 | Pointer command: 0 none, 1 single, 2 low twin, 3 high twin, 4 page |
| cmd_arg_i | input | 8 | Byte written by the command |
| opnd_work_i | input | 1 | 1: operand is a working register number |
| opnd_i | input | 8 | Operand (working mode uses bits 3:0) |
| addr_o | output | 8 | Absolute register file address |
| paged_o | output | 1 | Access falls in the paged top group |
| page_o | output | 6 | Page number for a paged access |
| rp_lo_o | output | 8 | Low pointer image |
| rp_hi_o | output | 8 | High pointer image |
| pg_o | output | 8 | Page pointer image |

## Verification
Two functions can fall in the same cycle: a pointer write, and a translation that depends on the pointer being written. The bench provokes this in two ways. It uses directed cycles that change the mode, window or page while an operand is being translated. It also runs a random phase in which commands and operands vary together every cycle.

Each result is judged against a behavioural model that applies the command only after the clock edge. The model therefore expects the old mapping in the write cycle and the new mapping in the cycle after it.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
   typedef enum logic [2:0] {
      RFX_NOP      = 3'd0,
      RFX_SET_ONE  = 3'd1,
      RFX_SET_LO   = 3'd2,
      RFX_SET_HI   = 3'd3,
      RFX_SET_PAGE = 3'd4
   } rfx_cmd_e;

   localparam int unsigned RFX_ADDR_W   = 8;
   localparam int unsigned RFX_NIB_W    = 4;
   localparam int unsigned RFX_PAGE_W   = 6;
   localparam logic [3:0]  RFX_WORK_ESC = 4'hD;
endpackage

// File: rtl/rfx_ptr_regs.sv
module rfx_ptr_regs
   import rfx_pkg::*;
#(
   parameter int unsigned ADDR_W = RFX_ADDR_W,
   parameter int unsigned NIB_W  = RFX_NIB_W,
   parameter int unsigned PAGE_W = RFX_PAGE_W,
   localparam int unsigned GRP_W = ADDR_W - (NIB_W - 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  rfx_cmd_e          cmd_i,
   input  logic [ADDR_W-1:0] arg_i,
   output logic [GRP_W-1:0]  lo_grp_o,
   output logic [GRP_W-1:0]  hi_grp_o,
   output logic              twin_o,
   output logic [PAGE_W-1:0] page_o
);
   generate
      if (PAGE_W > ADDR_W) begin : g_bad_page
         $error("rfx_ptr_regs: PAGE_W wider than ADDR_W");
      end
   endgenerate

   logic [GRP_W-1:0]  lo_q, hi_q;
   logic              twin_q;
   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q   <= '0;
         hi_q   <= '0;
         twin_q <= 1'b0;
         page_q <= '0;
      end else begin
         case (cmd_i)
            RFX_SET_ONE: begin
               lo_q   <= arg_i[ADDR_W-1 -: GRP_W];
               twin_q <= 1'b0;
            end
            RFX_SET_LO: begin
               lo_q   <= arg_i[ADDR_W-1 -: GRP_W];
               twin_q <= 1'b1;
            end
            RFX_SET_HI: begin
               hi_q   <= arg_i[ADDR_W-1 -: GRP_W];
               twin_q <= 1'b1;
            end
            RFX_SET_PAGE: page_q <= arg_i[ADDR_W-1 -: PAGE_W];
            default: ;
         endcase
      end
   end

   assign lo_grp_o = lo_q;
   assign hi_grp_o = hi_q;
   assign twin_o   = twin_q;
   assign page_o   = page_q;

   AST_SINGLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == RFX_SET_ONE) |=> (lo_grp_o == $past(arg_i[ADDR_W-1 -: GRP_W]) && !twin_o
                                  && $stable(hi_grp_o))); // R3
   AST_TWIN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == RFX_SET_LO || cmd_i == RFX_SET_HI) |=> twin_o); // R4
   AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == RFX_SET_HI) |=> (hi_grp_o == $past(arg_i[ADDR_W-1 -: GRP_W]))); // R4
   AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i != RFX_SET_PAGE) |=> $stable(page_o)); // R9
endmodule

// File: rtl/rfx_work_resolve.sv
module rfx_work_resolve #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned NIB_W   = 4,
   parameter bit          TWIN_EN = 1'b1,
   localparam int unsigned HALF_W = NIB_W - 1,
   localparam int unsigned GRP_W  = ADDR_W - HALF_W
) (
   input  logic [GRP_W-1:0]  lo_grp_i,
   input  logic [GRP_W-1:0]  hi_grp_i,
   input  logic              twin_i,
   input  logic [NIB_W-1:0]  wnum_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] single_addr;

   // Single window: 16-register aligned, so the lowest group bit is dropped
   assign single_addr = {lo_grp_i[GRP_W-1:1], wnum_i};

   generate
      if (TWIN_EN) begin : g_twin
         logic [ADDR_W-1:0] twin_addr;
         always_comb begin
            if (wnum_i[NIB_W-1]) twin_addr = {hi_grp_i, wnum_i[HALF_W-1:0]};
            else                 twin_addr = {lo_grp_i, wnum_i[HALF_W-1:0]};
         end
         assign addr_o = twin_i ? twin_addr : single_addr;
      end else begin : g_single
         logic unused_twin;
         assign unused_twin = twin_i ^ (^hi_grp_i);
         assign addr_o = single_addr;
      end
   endgenerate
endmodule

// File: rtl/rfx_page_map.sv
module rfx_page_map #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NIB_W  = 4,
   parameter int unsigned PAGE_W = 6
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PAGE_W-1:0] page_i,
   output logic              paged_o,
   output logic [PAGE_W-1:0] page_o
);
   assign paged_o = &addr_i[ADDR_W-1 -: NIB_W];
   assign page_o  = paged_o ? page_i : '0;
endmodule

// File: rtl/rf_addr_xlat.sv
module rf_addr_xlat
   import rfx_pkg::*;
#(
   parameter int unsigned ADDR_W  = RFX_ADDR_W,
   parameter int unsigned NIB_W   = RFX_NIB_W,
   parameter int unsigned PAGE_W  = RFX_PAGE_W,
   parameter bit          TWIN_EN = 1'b1,
   localparam int unsigned GRP_W  = ADDR_W - (NIB_W - 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        cmd_i,
   input  logic [ADDR_W-1:0] cmd_arg_i,
   input  logic              opnd_work_i,
   input  logic [ADDR_W-1:0] opnd_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              paged_o,
   output logic [PAGE_W-1:0] page_o,
   output logic [ADDR_W-1:0] rp_lo_o,
   output logic [ADDR_W-1:0] rp_hi_o,
   output logic [ADDR_W-1:0] pg_o
);
   generate
      if (ADDR_W != 2 * NIB_W) begin : g_bad_split
         $error("rf_addr_xlat: ADDR_W must be two nibbles");
      end
      if (PAGE_W + 2 != ADDR_W) begin : g_bad_pg
         $error("rf_addr_xlat: page field must leave two low bits");
      end
   endgenerate

   rfx_cmd_e          cmd_e;
   logic [GRP_W-1:0]  lo_grp, hi_grp;
   logic              twin;
   logic [PAGE_W-1:0] page_q;
   logic              use_work;
   logic [ADDR_W-1:0] work_addr;

   assign cmd_e = rfx_cmd_e'(cmd_i);

   rfx_ptr_regs #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_i    (cmd_e),
      .arg_i    (cmd_arg_i),
      .lo_grp_o (lo_grp),
      .hi_grp_o (hi_grp),
      .twin_o   (twin),
      .page_o   (page_q)
   );

   assign use_work = opnd_work_i ||
                     (opnd_i[ADDR_W-1 -: NIB_W] == NIB_W'(RFX_WORK_ESC));

   rfx_work_resolve #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .TWIN_EN(TWIN_EN)) u_work (
      .lo_grp_i (lo_grp),
      .hi_grp_i (hi_grp),
      .twin_i   (twin),
      .wnum_i   (opnd_i[NIB_W-1:0]),
      .addr_o   (work_addr)
   );

   assign addr_o = use_work ? work_addr : opnd_i;

   rfx_page_map #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .PAGE_W(PAGE_W)) u_page (
      .addr_i  (addr_o),
      .page_i  (page_q),
      .paged_o (paged_o),
      .page_o  (page_o)
   );

   assign rp_lo_o = {lo_grp, twin, 2'b00};
   assign rp_hi_o = {hi_grp, twin, 2'b00};
   assign pg_o    = {page_q, 2'b00};

   AST_ABS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!opnd_work_i && opnd_i[ADDR_W-1 -: NIB_W] != NIB_W'(RFX_WORK_ESC)) |-> addr_o == opnd_i); // R1
   AST_PAGE_NUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      paged_o |-> (page_o == pg_o[ADDR_W-1 -: PAGE_W])); // R2
   AST_TWIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opnd_work_i && rp_lo_o[2] && opnd_i[NIB_W-1]) |-> addr_o[ADDR_W-1 -: GRP_W] == rp_hi_o[ADDR_W-1 -: GRP_W]); // R7
   AST_ESC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      use_work |-> addr_o[NIB_W-2:0] == opnd_i[NIB_W-2:0]); // R8
endmodule

// File: tb/sim_rf_addr_xlat.sv
module sim_rf_addr_xlat;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic [7:0] arg = 8'h00;
   logic       work = 1'b0;
   logic [7:0] opnd = 8'h00;
   logic [7:0] addr, rp_lo, rp_hi, pg;
   logic       paged;
   logic [5:0] page;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int  m_lo, m_hi, m_pg;
   bit  m_twin;
   int  loaded = 0;           // bit0 lo, bit1 hi, bit2 page known
   string last_tag = "R5";

   always #10 clk = ~clk;

   rf_addr_xlat u0 (
      .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_arg_i(arg),
      .opnd_work_i(work), .opnd_i(opnd), .addr_o(addr), .paged_o(paged),
      .page_o(page), .rp_lo_o(rp_lo), .rp_hi_o(rp_hi), .pg_o(pg)
   );

   task automatic chk(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit is_work(bit w, logic [7:0] op);
      return w || (op[7:4] == 4'hD);
   endfunction

   function automatic int exp_addr(bit w, logic [7:0] op);
      int n;
      if (!is_work(w, op)) return int'(op);
      n = int'(op[3:0]);
      if (!m_twin) return (m_lo / 2) * 16 + n;
      if (n < 8) return m_lo * 8 + n;
      return m_hi * 8 + (n - 8);
   endfunction

   // One cycle: drive, compare combinational outputs, then apply model update after edge
   task automatic step(input logic [2:0] c, input logic [7:0] a, input bit w,
                       input logic [7:0] op, input string tag);
      int ea;
      string t;
      bool_blk: begin
         @(negedge clk);
         cmd = c; arg = a; work = w; opnd = op;
         #1;
         if (is_work(w, op) && (loaded & 3) != 3) begin
            // pointers not yet known: skip translation check
         end else begin
            ea = exp_addr(w, op);
            if (tag != "") t = tag;
            else if (!is_work(w, op)) t = "R1";
            else if (!w) t = "R8";
            else t = m_twin ? "R7" : "R6";
            chk(t, int'(addr), ea, "addr");
            if (ea >= 240) begin
               if (loaded[2]) chk("R2", int'(page), m_pg, "page");
               chk("R2", int'(paged), 1, "paged");
            end else begin
               chk((t == "R1") ? "R1" : "R2", int'(paged), 0, "paged");
               chk("R2", int'(page), 0, "page zero");
            end
         end
         chk("R5", int'(rp_lo[1:0]) + int'(rp_hi[1:0]) + int'(pg[1:0]), 0, "low bits");
         if (loaded[0]) chk(last_tag, int'(rp_lo), m_lo * 8 + (m_twin ? 4 : 0), "rp_lo");
         if (loaded[1]) chk(last_tag, int'(rp_hi), m_hi * 8 + (m_twin ? 4 : 0), "rp_hi");
         if (loaded[2]) chk((last_tag == "R9") ? "R9" : "R9_hold", int'(pg), m_pg * 4, "pg");
         @(posedge clk);
         case (c)
            3'd1: begin m_lo = int'(a[7:3]); m_twin = 1'b0; loaded |= 1; last_tag = "R3"; end
            3'd2: begin m_lo = int'(a[7:3]); m_twin = 1'b1; loaded |= 1; last_tag = "R4"; end
            3'd3: begin m_hi = int'(a[7:3]); m_twin = 1'b1; loaded |= 2; last_tag = "R4"; end
            3'd4: begin m_pg = int'(a[7:2]); loaded |= 4; last_tag = "R9"; end
            default: last_tag = "R5";
         endcase
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // Reset state: absolute operands pass through with no paging (R1)
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         opnd = 8'h10 * i + 8'h05; work = 1'b0;
         #1;
         chk("R1", int'(addr), int'(opnd), "reset addr");
         chk("R1", int'(paged), 0, "reset paged");
      end
      @(negedge clk); rst_n = 1'b1;

      // Load all pointers before any working translation; low bits written as 1 (R5)
      step(3'd2, 8'h63, 1'b0, 8'h20, "");   // low twin group 12
      step(3'd3, 8'h23, 1'b0, 8'h21, "");   // high twin group 4
      step(3'd4, 8'h17, 1'b0, 8'h22, "");   // page 5
      // R7: r12 with high group 4 -> 36
      step(3'd0, 8'h00, 1'b1, 8'h0C, "R7");
      step(3'd0, 8'h00, 1'b1, 8'h05, "R7");
      // R8: 0xD3 resolves as working r3
      step(3'd0, 8'h00, 1'b0, 8'hD3, "R8");
      step(3'd0, 8'h00, 1'b0, 8'hDA, "R8");
      // R2: group F paged with page 5; group E not paged
      step(3'd0, 8'h00, 1'b0, 8'hF2, "R2");
      step(3'd0, 8'h00, 1'b0, 8'hE7, "R1");
      // R3 and R6: single with odd group 3 acts as group 2
      step(3'd1, 8'h18, 1'b0, 8'h40, "");
      step(3'd0, 8'h00, 1'b1, 8'h07, "R6");
      step(3'd0, 8'h00, 1'b1, 8'h0F, "R6");
      // R10: command and translation together use old state
      step(3'd2, 8'hF8, 1'b1, 8'h09, "R10"); // old single mode
      step(3'd4, 8'h28, 1'b1, 8'h02, "R10"); // low twin group 31 -> 0xFA paged, old page 5
      step(3'd0, 8'h00, 1'b1, 8'h02, "R10"); // new page 10
      step(3'd1, 8'h70, 1'b1, 8'h0B, "R10"); // old twin mode, r11 via high
      step(3'd0, 8'h00, 1'b1, 8'h0B, "R6");
      // R9: unused codes change nothing
      step(3'd5, 8'hFF, 1'b0, 8'hF0, "R9");
      step(3'd7, 8'hFF, 1'b1, 8'h03, "R9");
      // Random mix
      for (int k = 0; k < 4000; k++) begin
         logic [2:0] rc;
         rc = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd0;
         step(rc, 8'($urandom), 1'($urandom), 8'($urandom), "");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule